// File: doc/BRIEF.md
# Write-Buffer Program Sequencer

This block sits behind the bus port of a flash controller and watches write cycles, each an address and a data word qualified by a write strobe. A three-cycle lead-in opens a buffered-program sequence. The next cycle gives a block address and a word count. Then one cycle per word fills a 16-entry local buffer. A final confirm cycle hands the buffer, its valid mask, the block number and the line base address to a program back-end. The request is held until the back-end returns a done pulse.

The sequence is checked as it runs. The block aborts on any of these: a word count above the buffer size, data cycles that do not share one 16-word line, a write after the last data cycle that is not the confirm, or a confirm aimed at a different block. On abort it sets a sticky flag. Only a dedicated clear command or the hardware reset leaves that state. A broken lead-in is not an error. The block just goes back to idle.

Top module: `wbuf_prog_seq`

## Requirements
- R1: After reset, `abort_flag` is 0, `prog_req` is 0 and `prog_mask` is all zero.
- R2: A sequence opens only after three consecutive writes match these pairs in order: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x25). A write that breaks the order returns the block to idle, leaves `abort_flag` at 0, and the writes that follow are not taken as a count, data or confirm cycle.
- R3: The write after the lead-in is the count cycle. Its data is the number of words minus one. A value above 15 sets `abort_flag` one cycle later.
- R4: Every data cycle must carry the same address bits 21:4 as the first data cycle, or `abort_flag` is set. `prog_line` shows those bits, with bits 3:0 as zero.
- R5: A data cycle writes its data into buffer slot address[3:0] and sets bit address[3:0] of `prog_mask`. A slot written more than once keeps the last data. Every data cycle uses up one of the count+1 slots, even when it repeats an address.
- R6: The write after the last data cycle must carry data 0x29, with address bits 21:15 equal to those of the count cycle. Any other data (for example a surplus data cycle), or a different block, sets `abort_flag`.
- R7: A good confirm raises `prog_req` one cycle later, with `prog_blk` equal to the count-cycle address bits 21:15. `prog_req`, `prog_blk`, `prog_line`, `prog_mask` and the buffer hold while `prog_done` is low, and every write is ignored during that time. `prog_done` drops the request and returns the block to idle.
- R8: While `abort_flag` is 1, every write is ignored except a write with data 0xF0 (any address), which clears the flag. Driving `rst_n` low also clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 22 | Write address |
| wr_data | input | 16 | Write data |
| prog_done | input | 1 | Back-end completion pulse |
| prog_req | output | 1 | Program request to the back-end |
| prog_blk | output | 7 | Block number of the request |
| prog_line | output | 22 | Line base address, low four bits zero |
| prog_mask | output | 16 | One bit per buffer slot that was written |
| buf_words | output | 256 | Buffer contents, slot k at bits 16k+15:16k |
| abort_flag | output | 1 | Sticky abort indication |

## Verification
The bench builds the block with its default values: 22 address bits, 16 data bits, a 16-word buffer and the block field starting at bit 15. With these values the count boundary sits at 15 against 16, and random word counts from 1 to 16 reach both a single-word load and a full buffer. Random slot indices inside a line make repeated addresses common, so the rule that the last write to a slot wins, and the rule that every data cycle uses up the count, are both exercised. The 22-bit address also allows random line and block values well away from zero, so the line and block comparisons are tested on their upper bits.

// File: rtl/wbps_pkg.sv
package wbps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_LOAD,
        ST_CONFIRM,
        ST_PROG,
        ST_ABORT
    } seq_state_e;
endpackage

// File: rtl/wbps_leadin.sv
module wbps_leadin #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int unsigned KEY0_ADDR = 'h555,
    parameter int unsigned KEY0_DATA = 'hAA,
    parameter int unsigned KEY1_ADDR = 'h2AA,
    parameter int unsigned KEY1_DATA = 'h55,
    parameter int unsigned KEY2_ADDR = 'h555,
    parameter int unsigned KEY2_DATA = 'h25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              done
);
    logic [1:0]        step_d, step_q;
    logic [ADDR_W-1:0] key_a;
    logic [DATA_W-1:0] key_d;

    always_comb begin
        case (step_q)
            2'd0:    begin key_a = ADDR_W'(KEY0_ADDR); key_d = DATA_W'(KEY0_DATA); end
            2'd1:    begin key_a = ADDR_W'(KEY1_ADDR); key_d = DATA_W'(KEY1_DATA); end
            default: begin key_a = ADDR_W'(KEY2_ADDR); key_d = DATA_W'(KEY2_DATA); end
        endcase
    end

    always_comb begin
        step_d = step_q;
        done   = 1'b0;
        if (!arm) begin
            step_d = 2'd0;
        end else if (wr_en) begin
            if (wr_addr == key_a && wr_data == key_d) begin
                if (step_q == 2'd2) begin
                    done   = 1'b1;
                    step_d = 2'd0;
                end else begin
                    step_d = step_q + 2'd1;
                end
            end else begin
                step_d = 2'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= 2'd0;
        else        step_q <= step_d;
    end

    // R2: the lead-in step counter never leaves its three legal values
    p_step_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_q != 2'd3);
    // R2: a write that breaks the lead-in sends the matcher back to the first pair
    p_break_resets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && wr_en && !(wr_addr == key_a && wr_data == key_d)) |=> step_q == 2'd0);
endmodule

// File: rtl/wbps_store.sv
module wbps_store #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr,
    input  logic [IDX_W-1:0]         idx,
    input  logic [DATA_W-1:0]        wdata,
    output logic [WORDS*DATA_W-1:0]  words,
    output logic [WORDS-1:0]         mask
);
    logic [DATA_W-1:0] mem_d [WORDS];
    logic [DATA_W-1:0] mem_q [WORDS];
    logic [WORDS-1:0]  mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        for (int i = 0; i < WORDS; i++) mem_d[i] = mem_q[i];
        if (clr) begin
            mask_d = '0;
        end else if (wr) begin
            mem_d[idx]  = wdata;
            mask_d[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else begin
            mask_q <= mask_d;
            for (int i = 0; i < WORDS; i++) mem_q[i] <= mem_d[i];
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_flat
        assign words[g*DATA_W +: DATA_W] = mem_q[g];
    end
    assign mask = mask_q;

    // R5: a load lands in its slot and marks it valid
    p_slot_written_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (mask_q[$past(idx)] && mem_q[$past(idx)] == $past(wdata)));
    // R5: a new sequence starts from an empty mask
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> mask_q == '0);
    // R7: with no load and no clear the buffer holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !clr) |=> ($stable(mask_q) && $stable(words)));
endmodule

// File: rtl/wbps_ctrl.sv
module wbps_ctrl
    import wbps_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 16,
    parameter int WORDS   = 16,
    parameter int BLK_LSB = 15,
    parameter int unsigned PROG_CMD = 'h29,
    parameter int unsigned CLR_CMD  = 'hF0,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int LINE_W = ADDR_W - IDX_W,
    localparam int BLK_W  = ADDR_W - BLK_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              leadin_done,
    input  logic              prog_done,
    output logic              arm,
    output logic              st_clr,
    output logic              st_wr,
    output logic [IDX_W-1:0]  st_idx,
    output logic              prog_req,
    output logic [BLK_W-1:0]  prog_blk,
    output logic [ADDR_W-1:0] prog_line,
    output logic              abort_flag
);
    localparam logic [DATA_W-1:0] MAX_WC = DATA_W'(WORDS - 1);
    localparam logic [DATA_W-1:0] P_CMD  = DATA_W'(PROG_CMD);
    localparam logic [DATA_W-1:0] C_CMD  = DATA_W'(CLR_CMD);

    typedef struct packed {
        seq_state_e        state;
        logic [BLK_W-1:0]  blk;
        logic [LINE_W-1:0] line;
        logic [IDX_W-1:0]  remain;
        logic              first;
    } ctrl_t;

    ctrl_t n_d, c_q;
    logic [LINE_W-1:0] in_line;
    logic [BLK_W-1:0]  in_blk;

    assign in_line = wr_addr[ADDR_W-1:IDX_W];
    assign in_blk  = wr_addr[ADDR_W-1:BLK_LSB];

    always_comb begin
        n_d    = c_q;
        st_clr = 1'b0;
        st_wr  = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (leadin_done) n_d.state = ST_COUNT;
            end
            ST_COUNT: begin
                if (wr_en) begin
                    if (wr_data > MAX_WC) begin
                        n_d.state = ST_ABORT;
                    end else begin
                        n_d.blk    = in_blk;
                        n_d.remain = wr_data[IDX_W-1:0];
                        n_d.first  = 1'b1;
                        st_clr     = 1'b1;
                        n_d.state  = ST_LOAD;
                    end
                end
            end
            ST_LOAD: begin
                if (wr_en) begin
                    if (!c_q.first && in_line != c_q.line) begin
                        n_d.state = ST_ABORT;
                    end else begin
                        st_wr     = 1'b1;
                        n_d.line  = in_line;
                        n_d.first = 1'b0;
                        if (c_q.remain == '0) n_d.state  = ST_CONFIRM;
                        else                  n_d.remain = c_q.remain - 1'b1;
                    end
                end
            end
            ST_CONFIRM: begin
                if (wr_en) begin
                    if (wr_data == P_CMD && in_blk == c_q.blk) n_d.state = ST_PROG;
                    else                                       n_d.state = ST_ABORT;
                end
            end
            ST_PROG: begin
                if (prog_done) n_d.state = ST_IDLE;
            end
            ST_ABORT: begin
                if (wr_en && wr_data == C_CMD) n_d.state = ST_IDLE;
            end
            default: n_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state  <= ST_IDLE;
            c_q.blk    <= '0;
            c_q.line   <= '0;
            c_q.remain <= '0;
            c_q.first  <= 1'b0;
        end else begin
            c_q <= n_d;
        end
    end

    assign arm        = (c_q.state == ST_IDLE);
    assign st_idx     = wr_addr[IDX_W-1:0];
    assign prog_req   = (c_q.state == ST_PROG);
    assign abort_flag = (c_q.state == ST_ABORT);
    assign prog_blk   = c_q.blk;
    assign prog_line  = {c_q.line, {IDX_W{1'b0}}};

    // R2: idle never leads straight into the abort state
    p_idle_no_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_IDLE) |=> !abort_flag);
    // R3: an oversized count aborts
    p_count_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_COUNT && wr_en && wr_data > MAX_WC) |=> abort_flag);
    // R4: a data cycle outside the line aborts
    p_line_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_LOAD && wr_en && !c_q.first && in_line != c_q.line) |=> abort_flag);
    // R6: anything but a matching confirm after the load aborts
    p_confirm_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_CONFIRM && wr_en && !(wr_data == P_CMD && in_blk == c_q.blk))
        |=> abort_flag);
    // R7: the request and its fields hold until done
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && !prog_done) |=> (prog_req && $stable(prog_blk) && $stable(prog_line)));
    // R7: the buffer is not written while the request is up
    p_req_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !(st_wr || st_clr));
    // R8: the abort flag is sticky until the clear command
    p_abort_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_flag && !(wr_en && wr_data == C_CMD)) |=> abort_flag);
endmodule

// File: rtl/wbuf_prog_seq.sv
module wbuf_prog_seq #(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 16,
    parameter int WORDS   = 16,
    parameter int BLK_LSB = 15,
    parameter int unsigned KEY0_ADDR = 'h555,
    parameter int unsigned KEY0_DATA = 'hAA,
    parameter int unsigned KEY1_ADDR = 'h2AA,
    parameter int unsigned KEY1_DATA = 'h55,
    parameter int unsigned LOAD_ADDR = 'h555,
    parameter int unsigned LOAD_CMD  = 'h25,
    parameter int unsigned PROG_CMD  = 'h29,
    parameter int unsigned CLR_CMD   = 'hF0,
    localparam int IDX_W = $clog2(WORDS),
    localparam int BLK_W = ADDR_W - BLK_LSB
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    prog_done,
    output logic                    prog_req,
    output logic [BLK_W-1:0]        prog_blk,
    output logic [ADDR_W-1:0]       prog_line,
    output logic [WORDS-1:0]        prog_mask,
    output logic [WORDS*DATA_W-1:0] buf_words,
    output logic                    abort_flag
);
    logic             arm, leadin_done, st_clr, st_wr;
    logic [IDX_W-1:0] st_idx;

    wbps_leadin #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .KEY0_ADDR(KEY0_ADDR), .KEY0_DATA(KEY0_DATA),
        .KEY1_ADDR(KEY1_ADDR), .KEY1_DATA(KEY1_DATA),
        .KEY2_ADDR(LOAD_ADDR), .KEY2_DATA(LOAD_CMD)
    ) u_leadin (
        .clk(clk), .rst_n(rst_n), .arm(arm), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(leadin_done)
    );

    wbps_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .BLK_LSB(BLK_LSB),
        .PROG_CMD(PROG_CMD), .CLR_CMD(CLR_CMD)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .leadin_done(leadin_done), .prog_done(prog_done),
        .arm(arm), .st_clr(st_clr), .st_wr(st_wr), .st_idx(st_idx),
        .prog_req(prog_req), .prog_blk(prog_blk), .prog_line(prog_line),
        .abort_flag(abort_flag)
    );

    wbps_store #(
        .DATA_W(DATA_W), .WORDS(WORDS)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .clr(st_clr), .wr(st_wr), .idx(st_idx),
        .wdata(wr_data), .words(buf_words), .mask(prog_mask)
    );

    // R1: request and abort are never raised together
    p_req_abort_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_req && abort_flag));
endmodule

// File: tb/wbuf_prog_seq_bench.sv
`timescale 1ns/1ps
module wbuf_prog_seq_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [21:0]  wr_addr = '0;
    logic [15:0]  wr_data = '0;
    logic         prog_done = 1'b0;
    logic         prog_req;
    logic [6:0]   prog_blk;
    logic [21:0]  prog_line;
    logic [15:0]  prog_mask;
    logic [255:0] buf_words;
    logic         abort_flag;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [15:0] exp_mem [16];
    logic [15:0] exp_mask;

    always #2.5 clk = ~clk;

    wbuf_prog_seq u_wbuf_prog_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_done(prog_done), .prog_req(prog_req),
        .prog_blk(prog_blk), .prog_line(prog_line), .prog_mask(prog_mask),
        .buf_words(buf_words), .abort_flag(abort_flag)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    task automatic wr(logic [21:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic leadin();
        wr(22'h555, 16'hAA);
        wr(22'h2AA, 16'h55);
        wr(22'h555, 16'h25);
    endtask

    task automatic clear_abort();
        wr(22'($urandom), 16'hF0);
        chk("R8 clear command", abort_flag, 0);
    endtask

    function automatic logic [21:0] line_addr(logic [17:0] ln, logic [3:0] ix);
        return {ln, ix};
    endfunction

    task automatic check_buffer(string tag);
        chk({tag, " mask"}, prog_mask, exp_mask);
        for (int k = 0; k < 16; k++)
            if (exp_mask[k]) chk({tag, " word"}, buf_words[k*16 +: 16], exp_mem[k]);
    endtask

    task automatic release_req();
        @(negedge clk); prog_done = 1'b1;
        @(negedge clk); prog_done = 1'b0;
        chk("R7 done drops request", prog_req, 0);
        chk("R7 idle after done", abort_flag, 0);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 abort at reset", abort_flag, 0);
        chk("R1 req at reset", prog_req, 0);
        chk("R1 mask at reset", prog_mask, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 broken lead-in then would-be count/data/confirm
        wr(22'h555, 16'hAA);
        wr(22'h2AA, 16'h54);
        wr(22'h555, 16'h25);
        wr(22'h008000, 16'd0);
        wr(22'h000010, 16'h1234);
        wr(22'h008000, 16'h29);
        chk("R2 broken lead-in no abort", abort_flag, 0);
        chk("R2 broken lead-in no request", prog_req, 0);

        // R3 count boundary: 16 aborts
        leadin();
        wr(22'h008000, 16'd16);
        chk("R3 count 16 aborts", abort_flag, 1);
        // R8 sticky against other writes, including the lead-in
        leadin();
        wr(22'h008000, 16'h29);
        wr(22'h0, 16'h00F1);
        chk("R8 sticky abort", abort_flag, 1);
        chk("R8 no request while aborted", prog_req, 0);
        clear_abort();

        // R3 count 15 is accepted, full buffer
        leadin();
        wr(22'h010000, 16'd15);
        chk("R3 count 15 accepted", abort_flag, 0);
        for (int k = 0; k < 16; k++) wr(line_addr(18'h01000, 4'(k)), 16'(k * 3 + 1));
        chk("R3 full load no abort", abort_flag, 0);
        wr(22'h010123, 16'h29);
        chk("R7 full buffer request", prog_req, 1);
        chk("R5 full mask", prog_mask, 16'hFFFF);
        release_req();

        // R4 line mismatch
        leadin();
        wr(22'h008000, 16'd3);
        wr(line_addr(18'h00800, 4'd0), 16'h1);
        wr(line_addr(18'h00801, 4'd1), 16'h2);
        chk("R4 line mismatch aborts", abort_flag, 1);
        clear_abort();

        // R6 surplus data cycle
        leadin();
        wr(22'h008000, 16'd1);
        wr(line_addr(18'h00800, 4'd2), 16'h11);
        wr(line_addr(18'h00800, 4'd3), 16'h22);
        chk("R6 load done no abort", abort_flag, 0);
        wr(line_addr(18'h00800, 4'd4), 16'h33);
        chk("R6 surplus data aborts", abort_flag, 1);
        clear_abort();

        // R6 confirm to another block
        leadin();
        wr(22'h008000, 16'd0);
        wr(line_addr(18'h00800, 4'd5), 16'h44);
        wr(22'h010000, 16'h29);
        chk("R6 block mismatch aborts", abort_flag, 1);
        chk("R6 no request on mismatch", prog_req, 0);

        // R8 hardware reset clears abort
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R8 reset clears abort", abort_flag, 0);

        // R5 repeated address consumes count, last data kept
        leadin();
        wr(22'h018000, 16'd2);
        wr(line_addr(18'h01805, 4'd9), 16'hAAAA);
        wr(line_addr(18'h01805, 4'd9), 16'hBBBB);
        wr(line_addr(18'h01805, 4'd9), 16'hCCCC);
        wr(22'h018000, 16'h29);
        chk("R5 repeat consumes count", prog_req, 1);
        chk("R5 single slot mask", prog_mask, 16'h0200);
        chk("R5 last data kept", buf_words[9*16 +: 16], 16'hCCCC);
        chk("R4 line output", prog_line, 22'h018050);
        release_req();

        // random sequences
        for (int it = 0; it < 60; it++) begin
            int n;
            logic [17:0] ln;
            logic [21:0] ba;
            n  = $urandom_range(1, 16);
            ln = 18'($urandom);
            ba = 22'($urandom);
            exp_mask = '0;
            leadin();
            wr(ba, 16'(n - 1));
            for (int k = 0; k < n; k++) begin
                logic [3:0]  ix;
                logic [15:0] d;
                ix = 4'($urandom_range(0, 15));
                d  = 16'($urandom);
                wr(line_addr(ln, ix), d);
                exp_mem[ix] = d;
                exp_mask[ix] = 1'b1;
            end
            chk("R5 no request before confirm", prog_req, 0);
            wr({ba[21:15], 15'($urandom)}, 16'h29);
            chk("R7 request raised", prog_req, 1);
            chk("R7 block", prog_blk, ba[21:15]);
            chk("R4 line", prog_line, {ln, 4'h0});
            check_buffer("R5 random");
            // R7 writes ignored while request is up
            leadin();
            wr(line_addr(ln, 4'($urandom)), 16'($urandom));
            wr(22'($urandom), 16'hF0);
            wr(22'($urandom), 16'd20);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            chk("R7 request held", prog_req, 1);
            chk("R7 no abort while held", abort_flag, 0);
            check_buffer("R7 held");
            release_req();
        end
        summary();
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                nchk++;
                nfail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                summary();
            end
        end
    end
endmodule